// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time at one-second resolution. A prescaler divides the base clock by `DIV`, which is 32768 by default, and emits a one-cycle second strobe. Each strobe moves a calendar forward by one second. The calendar holds seconds, minutes, hours, a day-of-week counter, day of month, month and a three-digit year. It applies the real month lengths and the Gregorian leap-year rule. The calendar year is `YEAR_BASE` plus the stored three-digit year.

Software reaches the block through a small register file with one write port and one combinational read port. Every time field is read and written in packed BCD. A control register holds the run bit. While the run bit is clear, the prescaler is stopped and the time fields cannot be written. Setting the run bit from 0 to 1 restarts the prescaler from a full period.

Every register access completes in one cycle. There is no back-pressure on this interface: a write presented with `wr_en` high is taken on that clock edge. The read data always follows `rd_addr`.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the run bit is 0 and `sec_tick` is low. The time reads as year 000, month 01, day 01, day-of-week 00, 00:00:00.
- R2: Register address 0 is control, and bit 0 is the run bit. Writing 1 there while the run bit is 0 restarts the prescaler. `sec_tick` is then high for one cycle, DIV-1 cycles after that write's clock edge, and again every DIV cycles after that. Writing 1 while the run bit is already 1 does not restart the period. Writing 0 stops the strobes.
- R3: On each strobe the seconds advance. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and start a new day.
- R4: On each new day the day-of-week field (address 4) counts 0 to 6 and then returns to 0. It does this independently of the date.
- R5: On a new day the day of month (address 5) increments. When it passes the length of the current month, it becomes 01 and the month increments. The month lengths are: 31 for January, March, May, July, August, October and December; 30 for April, June, September and November; 28 for February.
- R6: February has 29 days when YEAR_BASE+year is divisible by 4 and is either not divisible by 100 or divisible by 400. With the default base, years 000 and 400 are leap years and year 100 is not.
- R7: After December the month wraps to January and the year (address 7) increments. Year 999 wraps to 000.
- R8: The address map is: 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 day of month, 6 month, 7 year. Fields at addresses 1 to 6 use two BCD digits in bits [7:0]. The month is written and read as 01 to 12. The year places its tens and units digits in bits [7:0] and its hundreds digit in bits [11:8].
- R9: Writes to addresses 1 to 7 are ignored while the run bit is 0.
- R10: A field write in the same cycle as a strobe overrides that one field. The other fields still advance, including any carry out of the overwritten field.
- R11: A stored day of month of 00 becomes 01 on the next new day, and the month does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 12 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 12 | Read data for `rd_addr` (combinational) |
| sec_tick | output | 1 | One-cycle strobe that advances the calendar |

## Verification
The hardest situation to reach from the ports is a field write that lands on the one cycle in DIV in which the strobe is high, while a carry is due out of that field. The bench watches `sec_tick` and issues the write in that same cycle, with the seconds set to 59. It then checks that the minutes still advanced. Dates at the ends of months, years and centuries are reached by loading the time just before the boundary, running a counted number of strobes and then stopping the run bit, so the fields can be read while they are frozen. A short DIV keeps each simulated second to 64 cycles.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int RTC_AW = 3;
  localparam int RTC_DW = 12;

  typedef enum logic [RTC_AW-1:0] {
    RA_CTRL = 3'd0,
    RA_SEC  = 3'd1,
    RA_MIN  = 3'd2,
    RA_HOUR = 3'd3,
    RA_WDAY = 3'd4,
    RA_MDAY = 3'd5,
    RA_MON  = 3'd6,
    RA_YEAR = 3'd7
  } rtc_addr_e;

  // Binary time state; month is kept zero-based.
  typedef struct packed {
    logic [10:0] yr;
    logic [7:0]  mon;
    logic [7:0]  mday;
    logic [7:0]  wday;
    logic [7:0]  hour;
    logic [7:0]  min;
    logic [7:0]  sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return ({4'b0, b[7:4]} * 8'd10) + {4'b0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
    logic [7:0] r, t, o;
    r = v % 8'd100;
    t = r / 8'd10;
    o = r % 8'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [10:0] year_from_bcd(input logic [11:0] w);
    return {3'b0, bcd_to_bin(w[7:0])} + ({7'b0, w[11:8]} * 11'd100);
  endfunction

  function automatic logic [11:0] year_to_bcd(input logic [10:0] y);
    logic [10:0] v, h, lo;
    v  = y % 11'd1000;
    h  = v / 11'd100;
    lo = v % 11'd100;
    return {h[3:0], bin_to_bcd(lo[7:0])};
  endfunction

  function automatic logic is_leap(input logic [10:0] yr, input int base);
    int full;
    full = base + int'({21'b0, yr});
    return ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m0, input logic leap);
    logic [7:0] d;
    case (m0)
      8'd1:                      d = leap ? 8'd29 : 8'd28;
      8'd3, 8'd5, 8'd8, 8'd10:   d = 8'd30;
      default:                   d = 8'd31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
    end else if (start) begin
      cnt_q <= RELOAD;
    end else if (run) begin
      cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int YEAR_BASE = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              wr,
  input  rtc_addr_e         waddr,
  input  logic [RTC_DW-1:0] wdata,
  output rtc_time_t         cal_o
);
  localparam rtc_time_t RST_TIME = '{yr: '0, mon: '0, mday: 8'd1, wday: '0,
                                     hour: '0, min: '0, sec: '0};

  rtc_time_t cur_q, stepped, nxt;
  logic      leap;
  logic [7:0] dim;
  logic      c_min, c_hour, c_day, c_mon, c_yr;

  assign leap = is_leap(cur_q.yr, YEAR_BASE);
  assign dim  = month_len(cur_q.mon, leap);

  // Carry chain of one advance step.
  assign c_min  = (cur_q.sec  >= 8'd59);
  assign c_hour = c_min  && (cur_q.min  >= 8'd59);
  assign c_day  = c_hour && (cur_q.hour >= 8'd23);
  assign c_mon  = c_day  && (cur_q.mday != 8'd0) && (cur_q.mday >= dim);
  assign c_yr   = c_mon  && (cur_q.mon  >= 8'd11);

  always_comb begin
    stepped = cur_q;
    stepped.sec = c_min ? 8'd0 : cur_q.sec + 8'd1;
    if (c_min)  stepped.min  = c_hour ? 8'd0 : cur_q.min + 8'd1;
    if (c_hour) stepped.hour = c_day ? 8'd0 : cur_q.hour + 8'd1;
    if (c_day) begin
      stepped.wday = (cur_q.wday >= 8'd6) ? 8'd0 : cur_q.wday + 8'd1;
      if (cur_q.mday == 8'd0) stepped.mday = 8'd1;
      else                    stepped.mday = c_mon ? 8'd1 : cur_q.mday + 8'd1;
    end
    if (c_mon) stepped.mon = c_yr ? 8'd0 : cur_q.mon + 8'd1;
    if (c_yr)  stepped.yr  = (cur_q.yr >= 11'd999) ? 11'd0 : cur_q.yr + 11'd1;
  end

  // The written field wins over the advanced value.
  always_comb begin
    nxt = adv ? stepped : cur_q;
    if (wr) begin
      case (waddr)
        RA_SEC:  nxt.sec  = bcd_to_bin(wdata[7:0]);
        RA_MIN:  nxt.min  = bcd_to_bin(wdata[7:0]);
        RA_HOUR: nxt.hour = bcd_to_bin(wdata[7:0]);
        RA_WDAY: nxt.wday = bcd_to_bin(wdata[7:0]);
        RA_MDAY: nxt.mday = bcd_to_bin(wdata[7:0]);
        RA_MON:  nxt.mon  = bcd_to_bin(wdata[7:0]) - 8'd1;
        RA_YEAR: nxt.yr   = year_from_bcd(wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= RST_TIME;
    else        cur_q <= nxt;
  end

  assign cal_o = cur_q;

endmodule

// File: rtl/rtc_readmux.sv
module rtc_readmux
  import rtc_cal_pkg::*;
(
  input  rtc_time_t         cal_i,
  input  logic              run_i,
  input  logic [RTC_AW-1:0] addr,
  output logic [RTC_DW-1:0] data
);
  always_comb begin
    case (rtc_addr_e'(addr))
      RA_CTRL: data = {11'b0, run_i};
      RA_SEC:  data = {4'b0, bin_to_bcd(cal_i.sec)};
      RA_MIN:  data = {4'b0, bin_to_bcd(cal_i.min)};
      RA_HOUR: data = {4'b0, bin_to_bcd(cal_i.hour)};
      RA_WDAY: data = {4'b0, bin_to_bcd(cal_i.wday)};
      RA_MDAY: data = {4'b0, bin_to_bcd(cal_i.mday)};
      RA_MON:  data = {4'b0, bin_to_bcd(cal_i.mon + 8'd1)};
      RA_YEAR: data = year_to_bcd(cal_i.yr);
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_cal_pkg::*;
#(
  parameter int DIV       = 32768,
  parameter int YEAR_BASE = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RTC_AW-1:0] wr_addr,
  input  logic [RTC_DW-1:0] wr_data,
  input  logic [RTC_AW-1:0] rd_addr,
  output logic [RTC_DW-1:0] rd_data,
  output logic              sec_tick
);
  rtc_addr_e waddr;
  logic      run_q;
  logic      ctrl_wr, time_wr, start;
  rtc_time_t cal;

  assign waddr   = rtc_addr_e'(wr_addr);
  assign ctrl_wr = wr_en && (waddr == RA_CTRL);
  assign time_wr = wr_en && (waddr != RA_CTRL) && run_q;
  assign start   = ctrl_wr && wr_data[0] && !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (ctrl_wr) run_q <= wr_data[0];
  end

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .start (start),
    .tick  (sec_tick)
  );

  rtc_calendar #(.YEAR_BASE(YEAR_BASE)) u_cal (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (sec_tick),
    .wr    (time_wr),
    .waddr (waddr),
    .wdata (wr_data),
    .cal_o (cal)
  );

  rtc_readmux u_rd (
    .cal_i (cal),
    .run_i (run_q),
    .addr  (rd_addr),
    .data  (rd_data)
  );

endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk
  import rtc_cal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              sec_tick,
  input logic              time_wr,
  input logic [RTC_AW-1:0] wr_addr,
  input logic [7:0]        wr_lo,
  input rtc_time_t         cal
);
  // R2
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> run_q);

  // R2
  tick_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R9
  frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cal));

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !time_wr && cal.sec < 8'd58) |=> cal.sec == $past(cal.sec) + 8'd1);

  // R11
  mday_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !time_wr && cal.hour == 8'd23 && cal.min == 8'd59 && cal.sec == 8'd59)
      |=> cal.mday != 8'd0);

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_wr && wr_addr == RA_SEC) |=> cal.sec == bcd_to_bin($past(wr_lo)));

endmodule

bind bcd_calendar_rtc rtc_cal_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_q    (run_q),
  .sec_tick (sec_tick),
  .time_wr  (time_wr),
  .wr_addr  (wr_addr),
  .wr_lo    (wr_data[7:0]),
  .cal      (cal)
);

// File: tb/tb_bcd_calendar_rtc.sv
module tb_bcd_calendar_rtc;
  localparam int DIV  = 64;
  localparam int BASE = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [2:0]  man_addr = '0;
  logic        sweep = 1'b0;
  logic [11:0] rd_data;
  logic        sec_tick;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  bcd_calendar_rtc #(.DIV(DIV), .YEAR_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick)
  );

  // ---------------- reference model ----------------
  int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_yr, m_en, m_cnt;

  function automatic int mdays(int mon0, int yr);
    int full;
    full = BASE + yr;
    if (mon0 == 1)
      return (full % 4 == 0 && (full % 100 != 0 || full % 400 == 0)) ? 29 : 28;
    if (mon0 == 3 || mon0 == 5 || mon0 == 8 || mon0 == 10) return 30;
    return 31;
  endfunction

  function automatic int dec(int b);
    return ((b >> 4) & 15) * 10 + (b & 15);
  endfunction

  function automatic int enc(int v);
    return (((v % 100) / 10) << 4) | (v % 10);
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0: return m_en;
      1: return enc(m_sec);
      2: return enc(m_min);
      3: return enc(m_hour);
      4: return enc(m_wday);
      5: return enc(m_mday);
      6: return enc(m_mon + 1);
      default: return (((m_yr % 1000) / 100) << 8) | enc(m_yr % 100);
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2";
      1, 2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R8";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_mday = 1; m_mon = 0; m_yr = 0;
      m_en = 0; m_cnt = DIV - 1;
    end else begin
      int new_en;
      new_en = m_en;
      if (m_en && m_cnt == 0) begin
        m_sec++;
        if (m_sec >= 60) begin
          m_sec = 0; m_min++;
          if (m_min >= 60) begin
            m_min = 0; m_hour++;
            if (m_hour >= 24) begin
              m_hour = 0;
              m_wday = (m_wday + 1) % 7;
              if (m_mday == 0) m_mday = 1;
              else begin
                m_mday++;
                if (m_mday > mdays(m_mon, m_yr)) begin
                  m_mday = 1; m_mon++;
                  if (m_mon >= 12) begin
                    m_mon = 0;
                    m_yr = (m_yr >= 999) ? 0 : m_yr + 1;
                  end
                end
              end
            end
          end
        end
      end
      if (wr_en && wr_addr == 0 && wr_data[0] && !m_en) m_cnt = DIV - 1;
      else if (m_en) m_cnt = (m_cnt == 0) ? DIV - 1 : m_cnt - 1;
      if (wr_en) begin
        if (wr_addr == 0) new_en = int'(wr_data[0]);
        else if (m_en) begin
          case (wr_addr)
            3'd1: m_sec  = dec(int'(wr_data[7:0]));
            3'd2: m_min  = dec(int'(wr_data[7:0]));
            3'd3: m_hour = dec(int'(wr_data[7:0]));
            3'd4: m_wday = dec(int'(wr_data[7:0]));
            3'd5: m_mday = dec(int'(wr_data[7:0]));
            3'd6: m_mon  = dec(int'(wr_data[7:0])) - 1;
            default: m_yr = dec(int'(wr_data[7:0])) + int'(wr_data[11:8]) * 100;
          endcase
        end
      end
      m_en = new_en;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (sweep) rd_addr = rd_addr + 3'd1;
    else       rd_addr = man_addr;
    #3;
    if (rst_n) begin
      checks++;
      if (int'(sec_tick) != (m_en != 0 && m_cnt == 0 ? 1 : 0)) begin
        errors++;
        $display("FAIL R2 sec_tick: actual=%0d expected=%0d", sec_tick,
                 (m_en != 0 && m_cnt == 0) ? 1 : 0);
      end
      checks++;
      if (int'(rd_data) != exp_rd(int'(rd_addr))) begin
        errors++;
        $display("FAIL %s addr %0d: actual=%h expected=%h", tag_of(int'(rd_addr)),
                 rd_addr, rd_data, exp_rd(int'(rd_addr)));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 12'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input int a, input int v, input string tag);
    man_addr = 3'(a);
    @(negedge clk); #4;
    checks++;
    if (int'(rd_data) != v) begin
      errors++;
      $display("FAIL %s read addr %0d: actual=%h expected=%h", tag, a, rd_data, v);
    end
    #(-3 + 3);
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int wd,
                          input int h, input int mi, input int s);
    wr(0, 0); wr(0, 1);
    wr(7, y); wr(6, mo); wr(5, d); wr(4, wd); wr(3, h); wr(2, mi); wr(1, s);
  endtask

  task automatic run_secs(input int n);
    int c;
    c = 0;
    sweep = 1'b1;
    while (c < n) begin
      @(negedge clk); #1;
      if (sec_tick) c++;
    end
    wr(0, 0);
    sweep = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    expect_rd(0, 12'h000, "R1");
    expect_rd(1, 12'h000, "R1");
    expect_rd(5, 12'h001, "R1");
    expect_rd(6, 12'h001, "R1");
    expect_rd(7, 12'h000, "R1");
    #1;

    // R9 writes while stopped are ignored
    wr(1, 'h33); wr(7, 'h555); wr(6, 'h07);
    expect_rd(1, 12'h000, "R9");
    expect_rd(7, 12'h000, "R9");
    expect_rd(6, 12'h001, "R9");
    #1;

    // R2 first strobe DIV-1 cycles after enabling edge
    wr(0, 1);
    c = 1;
    while (!sec_tick) begin @(negedge clk); #1; c++; end
    checks++;
    if (c != DIV) begin errors++; $display("FAIL R2 first strobe: actual=%0d expected=%0d", c, DIV); end
    // R2 rewriting 1 while running keeps the period
    @(negedge clk); #1;
    wr(0, 1);
    c = 2;
    while (!sec_tick) begin @(negedge clk); #1; c++; end
    checks++;
    if (c != DIV) begin errors++; $display("FAIL R2 period kept: actual=%0d expected=%0d", c, DIV); end
    sweep = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    #1 sweep = 1'b0;

    // R6 R4 R3 leap year 2000: Feb 28 -> Feb 29, weekday 6 -> 0
    set_time('h000, 'h02, 'h28, 'h06, 'h23, 'h59, 'h58);
    run_secs(2);
    expect_rd(1, 12'h000, "R3");
    expect_rd(2, 12'h000, "R3");
    expect_rd(3, 12'h000, "R3");
    expect_rd(5, 12'h029, "R6");
    expect_rd(6, 12'h002, "R6");
    expect_rd(4, 12'h000, "R4");
    #1;

    // R6 year 100 not leap
    set_time('h100, 'h02, 'h28, 'h02, 'h23, 'h59, 'h59);
    run_secs(1);
    expect_rd(5, 12'h001, "R6");
    expect_rd(6, 12'h003, "R6");
    expect_rd(4, 12'h003, "R4");
    #1;

    // R6 year 400 leap
    set_time('h400, 'h02, 'h28, 'h01, 'h23, 'h59, 'h59);
    run_secs(1);
    expect_rd(5, 12'h029, "R6");
    expect_rd(7, 12'h400, "R8");
    #1;

    // R5 30-day month
    set_time('h024, 'h04, 'h30, 'h03, 'h23, 'h59, 'h59);
    run_secs(1);
    expect_rd(5, 12'h001, "R5");
    expect_rd(6, 12'h005, "R5");
    #1;

    // R7 year increment and 999 wrap
    set_time('h123, 'h12, 'h31, 'h05, 'h23, 'h59, 'h59);
    run_secs(1);
    expect_rd(7, 12'h124, "R7");
    expect_rd(6, 12'h001, "R7");
    #1;
    set_time('h999, 'h12, 'h31, 'h05, 'h23, 'h59, 'h59);
    run_secs(1);
    expect_rd(7, 12'h000, "R7");
    expect_rd(5, 12'h001, "R7");
    #1;

    // R11 day 00 forced to 01, month unchanged
    set_time('h050, 'h07, 'h00, 'h02, 'h23, 'h59, 'h59);
    run_secs(1);
    expect_rd(5, 12'h001, "R11");
    expect_rd(6, 12'h007, "R11");
    #1;

    // R10 write on the strobe cycle wins for seconds, carry still reaches minutes
    set_time('h050, 'h07, 'h10, 'h02, 'h08, 'h10, 'h59);
    while (!sec_tick) begin @(negedge clk); #1; end
    wr(1, 'h45);
    wr(0, 0);
    expect_rd(1, 12'h045, "R10");
    expect_rd(2, 12'h011, "R10");
    #1;

    // R2 stopped: no strobes, time frozen
    sweep = 1'b1;
    c = 0;
    repeat (3 * DIV) begin @(negedge clk); #1; if (sec_tick) c++; end
    sweep = 1'b0;
    checks++;
    if (c != 0) begin errors++; $display("FAIL R2 stopped strobes: actual=%0d expected=0", c); end
    expect_rd(1, 12'h045, "R2");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule